// File: doc/BRIEF.md
# Capture Edge Delay Filter

This block sits in front of one input-capture channel and decides whether an edge on the pin is real. The pin is brought into the bus clock domain through a two-stage synchroniser. An edge detector then picks out rising edges, falling edges or both, as the edge-select input asks. When a selected edge is seen, a down-counter is loaded with a programmed delay and the level the pin held before the edge is stored. When the counter runs out, the synchronised pin is compared with that stored level. A capture strobe lasting one bus cycle is raised only if the pin now sits at the opposite level. Pulses shorter than the delay therefore never reach the capture logic.

The delay comes from an 8-bit select value, read in one of two ways. In coarse mode only the two low bits count, and they pick off, 256, 512 or 1024 cycles. In fine mode the whole value n gives (n+1)*4 cycles, and zero means bypass. With the filter off, each selected edge is passed on at once, with no check. The capture register, the free-running timer and interrupt generation belong to the surrounding timer.

Top module: `capture_edge_filter`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, strobe_o is 0 and no count is in progress.
- R2: The pin passes through two synchroniser flops. In bypass, a change of pin_i applied between two clock edges makes strobe_o high in the cycle after the third following rising clock edge.
- R3: edge_sel_i encoding: 00 no edge accepted, 01 rising only, 10 falling only, 11 both edges. A change of pin_i of a kind that is not selected never produces a strobe.
- R4: With fine_mode_i = 0, only dly_sel_i[1:0] is used: 00 bypass, 01 256 cycles, 10 512 cycles, 11 1024 cycles. Bits [7:2] have no effect.
- R5: With fine_mode_i = 1 and dly_sel_i = n, the value n = 0 means bypass, and n > 0 gives a delay of (n+1)*4 cycles. A delay of D makes the strobe come D cycles later than it would in bypass.
- R6: At the end of a count, strobe_o is raised only if the synchronised pin differs from the level stored when the edge was taken. A pulse narrower than the delay produces no strobe.
- R7: While a count is running, further edges are ignored: the counter is neither restarted nor reloaded, and the stored level is kept.
- R8: The delay setting is read only when a count starts. A change to fine_mode_i or dly_sel_i during a count affects only the next count.
- R9: Every strobe lasts exactly one clock cycle.
- R10: In bypass, every accepted edge gives a strobe, with no level check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous capture pin |
| fine_mode_i | input | 1 | 1: fine delay formula, 0: coarse two-bit table |
| dly_sel_i | input | 8 | Delay select value |
| edge_sel_i | input | 2 | Edge select (00 off, 01 rise, 10 fall, 11 both) |
| strobe_o | output | 1 | Qualified capture strobe, one cycle wide |

## Verification
Some properties hold on every cycle and are checked continuously. A running count falls by exactly one per cycle and is never restarted. The stored reference level does not move during a count. No strobe appears while the count is above one. Every strobe follows either an expiring count or a bypassed edge. A disabled edge select never starts anything. Other properties only show up as timing over many cycles, so the bench scenarios cover them: the exact latency for each coarse and fine code, the rejection of glitches shorter than the delay, edges that arrive during a count, and a delay change in mid-count taking effect only on the next edge. A behavioural model in the bench predicts strobe_o on every cycle.

// File: rtl/ecq_pkg.sv
package ecq_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned FINE_STEP_LG = 2; // fine delay step of 4 cycles
endpackage

// File: rtl/ecq_sync.sv
module ecq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecq_edge_detect.sv
module ecq_edge_detect
  import ecq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  output logic       hit_o,
  output logic       prev_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (edge_mode_e'(mode_i))
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/ecq_delay_decode.sv
module ecq_delay_decode
  import ecq_pkg::*;
#(
  parameter int unsigned SEL_W       = 8,
  parameter int unsigned COARSE_BASE = 256,
  parameter int unsigned CNT_W       = 11
) (
  input  logic             fine_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] dly_o
);
  logic [CNT_W-1:0] fine_val, coarse_val;

  // (n+1) scaled by the fine step; n == 0 bypasses
  assign fine_val = (sel_i == '0) ? '0
                  : ((CNT_W'(sel_i) + CNT_W'(1)) << FINE_STEP_LG);

  always_comb begin
    unique case (sel_i[1:0])
      2'b01:   coarse_val = CNT_W'(COARSE_BASE);
      2'b10:   coarse_val = CNT_W'(COARSE_BASE * 2);
      2'b11:   coarse_val = CNT_W'(COARSE_BASE * 4);
      default: coarse_val = '0;
    endcase
  end

  assign dly_o = fine_i ? fine_val : coarse_val;
endmodule

// File: rtl/ecq_qualifier.sv
module ecq_qualifier #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             prev_i,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ref_o,
  output logic             strobe_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ref_q;
  logic             strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      ref_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) strobe_q <= (lvl_i != ref_q);
      end else if (hit_i) begin
        if (dly_i == '0) begin
          strobe_q <= 1'b1;
        end else begin
          cnt_q <= dly_i;
          ref_q <= prev_i;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign ref_o    = ref_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/capture_edge_filter.sv
module capture_edge_filter
  import ecq_pkg::*;
#(
  parameter int unsigned SEL_W       = 8,
  parameter int unsigned COARSE_BASE = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             fine_mode_i,
  input  logic [SEL_W-1:0] dly_sel_i,
  input  logic [1:0]       edge_sel_i,
  output logic             strobe_o
);
  localparam int unsigned FINE_MAX   = ((1 << SEL_W)) << FINE_STEP_LG;
  localparam int unsigned COARSE_MAX = COARSE_BASE * 4;
  localparam int unsigned DLY_MAX    = (FINE_MAX > COARSE_MAX) ? FINE_MAX : COARSE_MAX;
  localparam int unsigned CNT_W      = $clog2(DLY_MAX + 1);

  logic             lvl_w, hit_w, prev_w, ref_w;
  logic [CNT_W-1:0] dly_w, cnt_w;

  ecq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl_w)
  );

  ecq_edge_detect u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl_w), .mode_i(edge_sel_i),
    .hit_o(hit_w), .prev_o(prev_w)
  );

  ecq_delay_decode #(.SEL_W(SEL_W), .COARSE_BASE(COARSE_BASE), .CNT_W(CNT_W)) u_dec (
    .fine_i(fine_mode_i), .sel_i(dly_sel_i), .dly_o(dly_w)
  );

  ecq_qualifier #(.CNT_W(CNT_W)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_w), .prev_i(prev_w),
    .lvl_i(lvl_w), .dly_i(dly_w), .cnt_o(cnt_w), .ref_o(ref_w),
    .strobe_o(strobe_o)
  );
endmodule

// File: rtl/capture_edge_filter_chk.sv
module capture_edge_filter_chk #(
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned DLY_MAX = 1024
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       edge_sel_i,
  input logic             hit_i,
  input logic             ref_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             strobe_o
);
  a_r7_count_steps_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |=> (cnt_i == $past(cnt_i) - CNT_W'(1)));

  a_r7_ref_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i > CNT_W'(1)) |=> $stable(ref_i));

  a_r6_no_early_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i > CNT_W'(1)) |=> !strobe_o);

  a_r10_strobe_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> ($past(cnt_i) == CNT_W'(1) || $past(hit_i)));

  a_r3_off_is_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == 2'b00 && cnt_i == '0) |=> (!strobe_o && cnt_i == '0));

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DLY_MAX));
endmodule

bind capture_edge_filter capture_edge_filter_chk #(.CNT_W(CNT_W), .DLY_MAX(DLY_MAX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .edge_sel_i(edge_sel_i), .hit_i(hit_w),
  .ref_i(ref_w), .cnt_i(cnt_w), .strobe_o(strobe_o)
);

// File: tb/capture_edge_filter_test.sv
`timescale 1ns/1ps
module capture_edge_filter_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin = 1'b0;
  logic       fine = 1'b1;
  logic [7:0] sel = 8'd0;
  logic [1:0] esel = 2'b00;
  logic       strobe_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int pulses = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  capture_edge_filter uut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .fine_mode_i(fine),
    .dly_sel_i(sel), .edge_sel_i(esel), .strobe_o(strobe_o)
  );

  function automatic int ref_delay(bit f, int s);
    if (f) return (s == 0) ? 0 : (s + 1) * 4;
    case (s % 4)
      1: return 256;
      2: return 512;
      3: return 1024;
      default: return 0;
    endcase
  endfunction

  // behavioural reference: pin history and a deadline
  int m_hist[$];
  int m_left = 0;
  int m_ref = 0;
  bit exp_strobe = 1'b0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_hist = '{0, 0, 0};
      m_left = 0;
      m_ref = 0;
      exp_strobe = 1'b0;
    end else begin
      int now_l, old_l, d;
      bit take, nxt;
      cyc++;
      now_l = m_hist[1];
      old_l = m_hist[2];
      take = (now_l != old_l) &&
             ((esel == 2'b11) || (esel == 2'b01 && now_l == 1) || (esel == 2'b10 && now_l == 0));
      nxt = 1'b0;
      if (m_left > 0) begin
        if (m_left == 1) nxt = (now_l != m_ref);
        m_left--;
      end else if (take) begin
        d = ref_delay(fine, int'(sel));
        if (d == 0) nxt = 1'b1;
        else begin
          m_left = d;
          m_ref = old_l;
        end
      end
      m_hist.push_front(int'(pin));
      void'(m_hist.pop_back());
      exp_strobe = nxt;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("[TB] FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      if (strobe_o) pulses++;
      check({cur_req, " model"}, int'(strobe_o), int'(exp_strobe));
    end
  end

  task automatic drive_pin(logic v, output int c0);
    @(negedge clk);
    pin = v;
    c0 = cyc;
  endtask

  task automatic measure(int c0, int limit, output int got);
    got = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (strobe_o) begin
        got = cyc - c0;
        break;
      end
    end
  endtask

  task automatic expect_latency(string req, logic v, int lat);
    int c0, got;
    drive_pin(v, c0);
    measure(c0, lat + 8, got);
    check(req, got, lat);
    @(negedge clk);
    check({req, " R9 width"}, int'(strobe_o), 0);
  endtask

  task automatic expect_none(string req, logic v, int win);
    int c0, p0;
    drive_pin(v, c0);
    p0 = pulses;
    repeat (win) @(negedge clk);
    check(req, pulses - p0, 0);
  endtask

  task automatic park_low();
    @(negedge clk);
    esel = 2'b00;
    pin = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int c0, got;
    repeat (3) @(negedge clk);
    check("R1 reset", int'(strobe_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after reset", int'(strobe_o), 0);

    cur_req = "R10";
    fine = 1'b1; sel = 8'd0; esel = 2'b11;
    expect_latency("R2 R10 bypass rise", 1'b1, 3);
    expect_latency("R10 bypass fall", 1'b0, 3);

    cur_req = "R3";
    esel = 2'b00;
    expect_none("R3 off rise", 1'b1, 8);
    expect_none("R3 off fall", 1'b0, 8);
    esel = 2'b01;
    expect_latency("R3 rising only", 1'b1, 3);
    expect_none("R3 rising ignores fall", 1'b0, 8);
    esel = 2'b10;
    expect_none("R3 falling ignores rise", 1'b1, 8);
    expect_latency("R3 falling only", 1'b0, 3);

    cur_req = "R5";
    esel = 2'b01;
    sel = 8'd1;
    expect_latency("R5 fine n=1", 1'b1, 3 + 8);
    park_low();
    esel = 2'b01; sel = 8'd6;
    expect_latency("R5 fine n=6", 1'b1, 3 + 28);
    park_low();

    cur_req = "R4";
    fine = 1'b0; esel = 2'b01;
    sel = 8'hFD;
    expect_latency("R4 coarse 01 high bits ignored", 1'b1, 3 + 256);
    park_low();
    esel = 2'b01; sel = 8'h02;
    expect_latency("R4 coarse 10", 1'b1, 3 + 512);
    park_low();
    esel = 2'b01; sel = 8'h03;
    expect_latency("R4 coarse 11", 1'b1, 3 + 1024);
    park_low();
    esel = 2'b01; sel = 8'h04;
    expect_latency("R4 coarse 00 bypass", 1'b1, 3);
    park_low();

    cur_req = "R6";
    fine = 1'b1; sel = 8'd5; esel = 2'b11;
    drive_pin(1'b1, c0);
    repeat (5) @(negedge clk);
    expect_none("R6 glitch rejected", 1'b0, 60);

    cur_req = "R7";
    sel = 8'd10;
    drive_pin(1'b1, c0);
    repeat (6) @(negedge clk);
    pin = 1'b0;
    repeat (3) @(negedge clk);
    pin = 1'b1;
    measure(c0, 80, got);
    check("R7 no restart", got, 3 + 44);
    park_low();

    cur_req = "R8";
    esel = 2'b01; sel = 8'd10;
    drive_pin(1'b1, c0);
    repeat (5) @(negedge clk);
    sel = 8'd1;
    measure(c0, 80, got);
    check("R8 change mid-count", got, 3 + 44);
    park_low();
    esel = 2'b01;
    expect_latency("R8 new value next count", 1'b1, 3 + 8);
    park_low();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("[TB] FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule